// File: doc/BRIEF.md
# Programmable-Width CRC Engine

This block computes a cyclic redundancy check over a byte stream. It absorbs one data byte per clock, most significant bit first, and its width can be set anywhere from 1 to 32 bits. The generator polynomial, start value and final XOR mask are each supplied left-aligned in a 32-bit word: the upper `width` bits carry the value and the lower bits are ignored. No bit reflection is applied anywhere. The reset value and the intended default configuration give a 16-bit CRC with generator 0x8005, start value 0xFFFF and a zero final mask.

On the transmit side, the block is started with a one-cycle `init` pulse and fed the covered bytes. The right-justified `crc_out` is then appended to the frame. On the receive side, the block is fed the same bytes and the received checksum is presented on `rx_crc`. `crc_match` then reports whether the two agree. The result is combinational from the internal register, so it is valid in the cycle after the last byte. An option parameter can add an output register, which adds one cycle of latency.

Top module: `crc_msb_engine`

## Requirements
- R1: After reset the internal register holds 0xFFFF0000. With the 16-bit default configuration, `crc_out` then reads 0x0000FFFF.
- R2: Each cycle with `byte_valid` high absorbs `byte_data` from bit 7 down to bit 0. For each bit, the register shifts left by one. If the register's top bit differed from the data bit, the left-aligned polynomial is XORed into the shifted register. The updated value appears on `crc_out` after that clock edge.
- R3: `cfg_poly`, `cfg_init` and `cfg_xor` are left-aligned. Only bits [31:32-w] are used for width w. Bits below that have no effect on `crc_out`.
- R4: `cfg_width` selects a width w from 1 to 32. A value of 0, or any value above 32, is treated as 32.
- R5: `crc_out` equals (register XOR left-aligned final mask) shifted right by 32-w. Bits of `crc_out` at and above position w are always zero.
- R6: An `init` pulse loads the left-aligned start value. `init` takes priority over a `byte_valid` in the same cycle, and that byte is dropped.
- R7: While `init` and `byte_valid` are both low, the register and `crc_out` stay unchanged, whatever `byte_data` does.
- R8: `crc_match` is 1 exactly when `crc_out` equals the low w bits of `rx_crc`. Bits of `rx_crc` above w are ignored.
- R9: The expected check values are produced over the ASCII string "123456789":
  - With w=16, polynomial 0x80050000, start 0xFFFF0000 and mask 0, the result is 0xAEE7.
  - With w=8, polynomial 0x07000000, start 0 and mask 0, the result is 0xF4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 6 | CRC width in bits (0 or >32 means 32) |
| cfg_poly | input | 32 | Generator polynomial, left-aligned, implicit top term omitted |
| cfg_init | input | 32 | Start value, left-aligned |
| cfg_xor | input | 32 | Final XOR mask, left-aligned |
| init | input | 1 | Load the start value |
| byte_valid | input | 1 | Absorb `byte_data` this cycle |
| byte_data | input | 8 | Data byte, MSB processed first |
| rx_crc | input | 32 | Received checksum, right-justified |
| crc_out | output | 32 | Current checksum after final XOR, right-justified |
| crc_match | output | 1 | `crc_out` equals the low w bits of `rx_crc` |

## Verification
The main function is tried with every single-byte value under three configurations:
- the 16-bit default,
- an 8-bit generator,
- a 4-bit generator whose configuration words carry junk in their unused low bits.

The exhaustive byte sweeps separate errors in the bit order and the feedback decision from masking errors. The junk-bit case exposes any unused bit that leaks into the result. A multi-byte message is then run at every width from 1 to 32 with a non-zero final mask, together with the out-of-range width codes. This checks the alignment shift and the width clamp at both ends. Fixed check strings, same-cycle `init` with a byte, idle cycles with toggling data, and matching and mismatching received values cover the anchors, the priority, the hold and the compare.

// File: rtl/crc_msb_pkg.sv
package crc_msb_pkg;

   // Output stage variant of the engine.
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;

   localparam int unsigned CRC_REG_W_DFLT  = 32;
   localparam int unsigned CRC_DATA_W_DFLT = 8;
   localparam logic [31:0] CRC_RST_DFLT    = 32'hFFFF_0000;

endpackage

// File: rtl/crc_msb_width.sv
// Decodes the programmed width into a shift amount and two masks.
module crc_msb_width #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned W_BITS = $clog2(REG_W + 1)
) (
   input  logic [W_BITS-1:0] cfg_width,
   output logic [W_BITS-1:0] eff_width,
   output logic [W_BITS-1:0] shift_amt,
   output logic [REG_W-1:0]  hi_mask,
   output logic [REG_W-1:0]  lo_mask
);
   localparam logic [W_BITS-1:0] FULL_W = W_BITS'(REG_W);
   localparam logic [REG_W-1:0]  ONES   = {REG_W{1'b1}};

   generate
      if (W_BITS < $clog2(REG_W + 1)) begin : g_bad_wbits
         $error("crc_msb_width: W_BITS too small for REG_W");
      end
   endgenerate

   always_comb begin
      if (cfg_width == '0 || cfg_width > FULL_W) begin
         eff_width = FULL_W;
      end else begin
         eff_width = cfg_width;
      end
      shift_amt = FULL_W - eff_width;
      hi_mask   = ONES << shift_amt;
      lo_mask   = ONES >> shift_amt;
   end

endmodule

// File: rtl/crc_msb_bitstep.sv
// One serial CRC step on a left-aligned register.
module crc_msb_bitstep #(
   parameter int unsigned REG_W = 32
) (
   input  logic [REG_W-1:0] state_i,
   input  logic [REG_W-1:0] poly_i,
   input  logic             din_i,
   output logic [REG_W-1:0] state_o
);
   logic feedback;

   always_comb begin
      feedback = state_i[REG_W-1] ^ din_i;
      state_o  = {state_i[REG_W-2:0], 1'b0} ^ (feedback ? poly_i : '0);
   end

endmodule

// File: rtl/crc_msb_bytestep.sv
// Chains DATA_W serial steps so a whole word is absorbed in one cycle.
module crc_msb_bytestep #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned DATA_W = 8
) (
   input  logic [REG_W-1:0]  state_i,
   input  logic [REG_W-1:0]  poly_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [REG_W-1:0]  state_o
);
   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("crc_msb_bytestep: DATA_W must be at least 1");
      end
      for (genvar g = 0; g < DATA_W; g++) begin : g_bit
         logic [REG_W-1:0] s_in;
         logic [REG_W-1:0] s_out;
         if (g == 0) begin : g_first
            assign s_in = state_i;
         end else begin : g_next
            assign s_in = g_bit[g-1].s_out;
         end
         // data is consumed most significant bit first
         crc_msb_bitstep #(.REG_W(REG_W)) u_step (
            .state_i (s_in),
            .poly_i  (poly_i),
            .din_i   (data_i[DATA_W-1-g]),
            .state_o (s_out)
         );
      end
   endgenerate

   assign state_o = g_bit[DATA_W-1].s_out;

endmodule

// File: rtl/crc_msb_engine.sv
// Programmable-width, left-aligned, non-reflected CRC engine.
module crc_msb_engine #(
   parameter int unsigned            REG_W    = crc_msb_pkg::CRC_REG_W_DFLT,
   parameter int unsigned            DATA_W   = crc_msb_pkg::CRC_DATA_W_DFLT,
   parameter logic [REG_W-1:0]       RST_VAL  = REG_W'(crc_msb_pkg::CRC_RST_DFLT),
   parameter crc_msb_pkg::out_mode_e OUT_MODE = crc_msb_pkg::OUT_COMB
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(REG_W+1)-1:0]   cfg_width,
   input  logic [REG_W-1:0]             cfg_poly,
   input  logic [REG_W-1:0]             cfg_init,
   input  logic [REG_W-1:0]             cfg_xor,
   input  logic                         init,
   input  logic                         byte_valid,
   input  logic [DATA_W-1:0]            byte_data,
   input  logic [REG_W-1:0]             rx_crc,
   output logic [REG_W-1:0]             crc_out,
   output logic                         crc_match
);
   localparam int unsigned W_BITS = $clog2(REG_W + 1);

   generate
      if (REG_W < 2 || REG_W > 64) begin : g_bad_regw
         $error("crc_msb_engine: REG_W must lie in 2..64");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_dataw
         $error("crc_msb_engine: DATA_W must lie in 1..64");
      end
   endgenerate

   logic [W_BITS-1:0] eff_width;
   logic [W_BITS-1:0] shift_amt;
   logic [REG_W-1:0]  hi_mask;
   logic [REG_W-1:0]  lo_mask;
   logic [REG_W-1:0]  poly_m;
   logic [REG_W-1:0]  init_m;
   logic [REG_W-1:0]  xor_m;
   logic [REG_W-1:0]  crc_q;
   logic [REG_W-1:0]  crc_nxt;
   logic [REG_W-1:0]  result;
   logic              result_eq;

   crc_msb_width #(.REG_W(REG_W), .W_BITS(W_BITS)) u_width (
      .cfg_width (cfg_width),
      .eff_width (eff_width),
      .shift_amt (shift_amt),
      .hi_mask   (hi_mask),
      .lo_mask   (lo_mask)
   );

   // unused low bits of the left-aligned words are dropped here
   assign poly_m = cfg_poly & hi_mask;
   assign init_m = cfg_init & hi_mask;
   assign xor_m  = cfg_xor  & hi_mask;

   crc_msb_bytestep #(.REG_W(REG_W), .DATA_W(DATA_W)) u_byte (
      .state_i (crc_q),
      .poly_i  (poly_m),
      .data_i  (byte_data),
      .state_o (crc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= RST_VAL;
      end else if (init) begin
         crc_q <= init_m;
      end else if (byte_valid) begin
         crc_q <= crc_nxt;
      end
   end

   assign result    = (crc_q ^ xor_m) >> shift_amt;
   assign result_eq = (result == (rx_crc & lo_mask));

   generate
      if (OUT_MODE == crc_msb_pkg::OUT_REG) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               crc_out   <= '0;
               crc_match <= 1'b0;
            end else begin
               crc_out   <= result;
               crc_match <= result_eq;
            end
         end
      end else begin : g_out_comb
         assign crc_out   = result;
         assign crc_match = result_eq;
      end
   endgenerate

   // R6: a start pulse alone loads the aligned start value
   assert_init_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (init && !byte_valid) |=> (crc_q == $past(init_m)));

   // R6: a start pulse wins over a same-cycle byte
   assert_init_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (init && byte_valid) |=> (crc_q == $past(init_m)));

   // R7: idle cycles leave the register alone
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !byte_valid) |=> $stable(crc_q));

   // R2: an all-zero byte into an all-zero register produces no feedback
   assert_zero_absorb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && byte_valid && crc_q == '0 && byte_data == '0) |=> (crc_q == '0));

   // R5: nothing is visible above the selected width
   assert_out_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((result & ~lo_mask) == '0));

endmodule

// File: tb/tb_crc_msb_engine.sv
`timescale 1ns/1ps
module tb_crc_msb_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_width = 6'd16;
   logic [31:0] cfg_poly = 32'h8005_0000;
   logic [31:0] cfg_init = 32'hFFFF_0000;
   logic [31:0] cfg_xor = 32'h0;
   logic        init = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = 8'h0;
   logic [31:0] rx_crc = 32'h0;
   logic [31:0] crc_out;
   logic        crc_match;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] msg [16];
   int mlen;

   always #2.5 clk = ~clk;

   crc_msb_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_poly(cfg_poly),
      .cfg_init(cfg_init), .cfg_xor(cfg_xor), .init(init),
      .byte_valid(byte_valid), .byte_data(byte_data), .rx_crc(rx_crc),
      .crc_out(crc_out), .crc_match(crc_match)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // right-justified bit-serial reference, built from R2..R5
   function automatic logic [31:0] ref_crc(input int w, input logic [31:0] p,
         input logic [31:0] i, input logic [31:0] x, input int n);
      logic [31:0] lm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      logic [31:0] pr = p >> (32 - w);
      logic [31:0] r  = i >> (32 - w);
      for (int k = 0; k < n; k++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb = r[w-1] ^ msg[k][b];
            r = (r << 1) & lm;
            if (fb) r = r ^ pr;
         end
      end
      return (r ^ (x >> (32 - w))) & lm;
   endfunction

   task automatic start(input logic [5:0] w, input logic [31:0] p,
                        input logic [31:0] i, input logic [31:0] x);
      @(negedge clk);
      cfg_width = w; cfg_poly = p; cfg_init = i; cfg_xor = x;
      init = 1'b1;
      @(negedge clk);
      init = 1'b0;
   endtask

   task automatic feed(input logic [7:0] b);
      byte_valid = 1'b1; byte_data = b;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic run_msg(input logic [5:0] w, input logic [31:0] p, input logic [31:0] i,
                          input logic [31:0] x, input int refw, input string req);
      logic [31:0] e;
      start(w, p, i, x);
      for (int k = 0; k < mlen; k++) feed(msg[k]);
      e = ref_crc(refw, p, i, x, mlen);
      check(crc_out === e, req, crc_out, e);
   endtask

   initial begin
      #(100000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset value with default configuration
      check(crc_out === 32'h0000_FFFF, "R1 reset", crc_out, 32'h0000_FFFF);
      rst_n = 1'b1;
      @(negedge clk);
      check(crc_out === 32'h0000_FFFF, "R1 after release", crc_out, 32'h0000_FFFF);

      // R2: every single byte, 16-bit default
      mlen = 1;
      for (int v = 0; v < 256; v++) begin
         msg[0] = 8'(v);
         run_msg(6'd16, 32'h8005_0000, 32'hFFFF_0000, 32'h0, 16, "R2 crc16 byte");
      end
      // R2/R4: every single byte, 8-bit generator
      for (int v = 0; v < 256; v++) begin
         msg[0] = 8'(v);
         run_msg(6'd8, 32'h0700_0000, 32'h0, 32'h0, 8, "R2 crc8 byte");
      end
      // R3: 4-bit generator with junk below the used field
      for (int v = 0; v < 256; v++) begin
         logic [31:0] e;
         msg[0] = 8'(v);
         start(6'd4, 32'h3FFF_FFFF, 32'hFFFF_FFFF, 32'h0ABC_DEF1);
         feed(msg[0]);
         e = ref_crc(4, 32'h3000_0000, 32'hF000_0000, 32'h0, 1);
         check(crc_out === e, "R3 low bits ignored", crc_out, e);
      end

      // R4/R5: every width with a final mask
      mlen = 4;
      msg[0] = 8'hDE; msg[1] = 8'hAD; msg[2] = 8'h5A; msg[3] = 8'h01;
      for (int w = 1; w <= 32; w++) begin
         run_msg(6'(w), 32'hA5C3_9E17, 32'h9ABC_DEF0, 32'h0F0F_F0F0, w, "R5 width sweep");
      end
      // R4: out-of-range widths behave as 32
      run_msg(6'd0,  32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32, "R4 width 0");
      run_msg(6'd40, 32'h04C1_1DB7, 32'h1234_5678, 32'h0, 32, "R4 width 40");

      // R9: check strings
      mlen = 9;
      for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);
      start(6'd16, 32'h8005_0000, 32'hFFFF_0000, 32'h0);
      for (int k = 0; k < 9; k++) feed(msg[k]);
      check(crc_out === 32'h0000_AEE7, "R9 crc16 check", crc_out, 32'h0000_AEE7);
      start(6'd8, 32'h0700_0000, 32'h0, 32'h0);
      for (int k = 0; k < 9; k++) feed(msg[k]);
      check(crc_out === 32'h0000_00F4, "R9 crc8 check", crc_out, 32'h0000_00F4);

      // R6: init and a byte in the same cycle
      start(6'd16, 32'h8005_0000, 32'hFFFF_0000, 32'h0);
      feed(8'h12); feed(8'h34);
      init = 1'b1; byte_valid = 1'b1; byte_data = 8'h77;
      @(negedge clk);
      init = 1'b0; byte_valid = 1'b0;
      check(crc_out === 32'h0000_FFFF, "R6 init priority", crc_out, 32'h0000_FFFF);

      // R7: idle with toggling data
      mlen = 2; msg[0] = 8'h9C; msg[1] = 8'h3E;
      start(6'd16, 32'h8005_0000, 32'hFFFF_0000, 32'h0);
      feed(msg[0]); feed(msg[1]);
      for (int k = 0; k < 6; k++) begin
         byte_data = 8'(k * 37 + 5);
         @(negedge clk);
         check(crc_out === ref_crc(16, 32'h8005_0000, 32'hFFFF_0000, 32'h0, 2),
               "R7 idle hold", crc_out, ref_crc(16, 32'h8005_0000, 32'hFFFF_0000, 32'h0, 2));
      end

      // R8: compare against received value
      rx_crc = ref_crc(16, 32'h8005_0000, 32'hFFFF_0000, 32'h0, 2);
      #0.1;
      check(crc_match === 1'b1, "R8 match equal", {31'h0, crc_match}, 32'h1);
      rx_crc = rx_crc | 32'hABCD_0000;
      #0.1;
      check(crc_match === 1'b1, "R8 upper rx bits ignored", {31'h0, crc_match}, 32'h1);
      rx_crc = rx_crc ^ 32'h1;
      #0.1;
      check(crc_match === 1'b0, "R8 mismatch", {31'h0, crc_match}, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule